// File: doc/BRIEF.md
# Dual-Output Level Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources and produces two request outputs: a normal interrupt request and a fast interrupt request. Each source line sets its bit of the raw status word while the line is high. Two separate enable masks choose which sources drive each output. Software never writes a mask directly. It sets mask bits by writing ones to a set address and clears them by writing ones to a clear address. Either action changes only the bits written as one, so two drivers that share the controller do not overwrite each other's choices.

Source 0 has a second origin. A software latch, set and cleared through its own pair of addresses, is ORed with input line 0 to form raw bit 0. This lets firmware raise an interrupt on itself. Controllers can be cascaded: the request output of a child controller is wired as an ordinary level source to one input of a parent.

The register port uses byte addresses and decodes whole words. A request is accepted in the cycle in which `req_valid` is high. The port is always ready and never applies back-pressure. A read answers exactly one cycle later with `rsp_valid` high and the data on `rsp_rdata`. Writes give no response.

Top module: `dual_intc`

## Requirements
- R1: The word index is the byte address with its two low bits dropped (`req_addr[7:2]`). Address bits 1:0 have no effect on the decode.
- R2: Reading index 1 or index 9 returns the raw status word. Bit n follows source n for n ≥ 1. Bit 0 is source 0 ORed with the software latch.
- R3: A write to index 2 ORs the data into the IRQ enable mask. A write to index 3 clears the mask bits that are written as one. Reading index 2 returns the mask.
- R4: Indices 10 (set) and 11 (clear) update the FIQ enable mask in the same way. Reading index 10 returns the FIQ mask.
- R5: Reading index 0 returns raw AND IRQ mask. Reading index 8 returns raw AND FIQ mask.
- R6: A write to index 4 with data bit 0 high sets the software latch. A write to index 5 with data bit 0 high clears it. Writes to either index with bit 0 low change nothing. Reading index 4 returns raw bit 0 in bit 0, with all other bits zero.
- R7: `irq_out` is high exactly when any bit of raw AND IRQ mask was set at the previous clock edge. `fiq_out` behaves the same way with the FIQ mask.
- R8: Reads of indices 3, 5 and 11, and of every index not listed here, return zero.
- R9: Writes to indices 0, 1, 8 and 9 change no state.
- R10: Reset clears both masks, the software latch, both outputs and `rsp_valid`.
- R11: `rsp_valid` is high in the cycle after a read request is accepted and low at all other times. Write requests produce no response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_lvl | input | 32 | Level interrupt source lines |
| req_valid | input | 1 | Register request present (always accepted) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 8 | Byte address of the register |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| irq_out | output | 1 | Normal interrupt request |
| fiq_out | output | 1 | Fast interrupt request |

## Verification
The hardest state to reach from the ports is raw bit 0 driven only by the software latch, with input line 0 held low. It must also be shown that set and clear writes with data bit 0 low leave that latch alone. The stimulus reaches this state by first writing index 4 with every bit except bit 0 set, and reading raw status as zero. It then sets the latch and confirms that raw and IRQ-masked status both show bit 0 while the line stays low. Finally it makes a no-op clear write before the real clear. Status-index writes with all-ones data are placed while both masks and the latch hold known non-zero values, so that any stray decode would be visible in the next read.

// File: rtl/dintc_pkg.sv
package dintc_pkg;

  localparam int unsigned IX_IMASKED = 0;
  localparam int unsigned IX_IRAW    = 1;
  localparam int unsigned IX_IEN_SET = 2;
  localparam int unsigned IX_IEN_CLR = 3;
  localparam int unsigned IX_SW_SET  = 4;
  localparam int unsigned IX_SW_CLR  = 5;
  localparam int unsigned IX_FMASKED = 8;
  localparam int unsigned IX_FRAW    = 9;
  localparam int unsigned IX_FEN_SET = 10;
  localparam int unsigned IX_FEN_CLR = 11;

  typedef struct packed {
    logic ien_set;
    logic ien_clr;
    logic fen_set;
    logic fen_clr;
    logic sw_set;
    logic sw_clr;
  } wr_strobe_t;

  typedef enum logic [2:0] {
    RS_ZERO,
    RS_RAW,
    RS_IMASKED,
    RS_FMASKED,
    RS_IEN,
    RS_FEN,
    RS_SWBIT
  } rd_sel_t;

endpackage

// File: rtl/dintc_decode.sv
module dintc_decode
  import dintc_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic       req_valid,
  input  logic       req_write,
  input  logic [AW-1:0] req_addr,
  input  logic       wdata_bit0,
  output wr_strobe_t wstb,
  output rd_sel_t    rsel
);
  localparam int unsigned IXW = AW - 2;

  logic [IXW-1:0] idx;
  logic           do_wr;

  assign idx   = req_addr[AW-1:2];
  assign do_wr = req_valid && req_write;

  always_comb begin
    wstb = '0;
    if (do_wr) begin
      unique case (int'(idx))
        IX_IEN_SET: wstb.ien_set = 1'b1;
        IX_IEN_CLR: wstb.ien_clr = 1'b1;
        IX_FEN_SET: wstb.fen_set = 1'b1;
        IX_FEN_CLR: wstb.fen_clr = 1'b1;
        IX_SW_SET:  wstb.sw_set  = wdata_bit0;
        IX_SW_CLR:  wstb.sw_clr  = wdata_bit0;
        default:    wstb = '0;
      endcase
    end
  end

  always_comb begin
    unique case (int'(idx))
      IX_IMASKED: rsel = RS_IMASKED;
      IX_IRAW:    rsel = RS_RAW;
      IX_IEN_SET: rsel = RS_IEN;
      IX_SW_SET:  rsel = RS_SWBIT;
      IX_FMASKED: rsel = RS_FMASKED;
      IX_FRAW:    rsel = RS_RAW;
      IX_FEN_SET: rsel = RS_FEN;
      default:    rsel = RS_ZERO;
    endcase
  end

endmodule

// File: rtl/dintc_mask_reg.sv
module dintc_mask_reg #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_stb,
  input  logic         clr_stb,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] mask
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask <= '0;
    end else if (set_stb) begin
      mask <= mask | wdata;
    end else if (clr_stb) begin
      mask <= mask & ~wdata;
    end
  end
endmodule

// File: rtl/dintc_raw_gen.sv
module dintc_raw_gen #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sw_set,
  input  logic         sw_clr,
  input  logic [N-1:0] src,
  output logic         sw_q,
  output logic [N-1:0] raw
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q <= 1'b0;
    end else if (sw_set) begin
      sw_q <= 1'b1;
    end else if (sw_clr) begin
      sw_q <= 1'b0;
    end
  end

  for (genvar b = 0; b < N; b++) begin : g_raw
    if (b == 0) begin : g_sw
      assign raw[b] = src[b] | sw_q;
    end else begin : g_hw
      assign raw[b] = src[b];
    end
  end
endmodule

// File: rtl/dintc_out_gen.sv
module dintc_out_gen #(
  parameter int unsigned N = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] raw,
  input  logic [N-1:0] ien,
  input  logic [N-1:0] fen,
  output logic         irq_q,
  output logic         fiq_q
);
  logic irq_d;
  logic fiq_d;

  assign irq_d = |(raw & ien);
  assign fiq_d = |(raw & fen);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
      fiq_q <= 1'b0;
    end else begin
      irq_q <= irq_d;
      fiq_q <= fiq_d;
    end
  end
endmodule

// File: rtl/dual_intc.sv
module dual_intc
  import dintc_pkg::*;
#(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  src_lvl,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [N-1:0]  req_wdata,
  output logic          rsp_valid,
  output logic [N-1:0]  rsp_rdata,
  output logic          irq_out,
  output logic          fiq_out
);
  wr_strobe_t   wstb;
  rd_sel_t      rsel;
  logic [N-1:0] irq_en;
  logic [N-1:0] fiq_en;
  logic [N-1:0] raw;
  logic         sw_q;
  logic [N-1:0] rd_mux;

  dintc_decode #(.AW(AW)) u_dec (
    .req_valid (req_valid),
    .req_write (req_write),
    .req_addr  (req_addr),
    .wdata_bit0(req_wdata[0]),
    .wstb      (wstb),
    .rsel      (rsel)
  );

  dintc_mask_reg #(.N(N)) u_ien (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(wstb.ien_set),
    .clr_stb(wstb.ien_clr),
    .wdata  (req_wdata),
    .mask   (irq_en)
  );

  dintc_mask_reg #(.N(N)) u_fen (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_stb(wstb.fen_set),
    .clr_stb(wstb.fen_clr),
    .wdata  (req_wdata),
    .mask   (fiq_en)
  );

  dintc_raw_gen #(.N(N)) u_raw (
    .clk   (clk),
    .rst_n (rst_n),
    .sw_set(wstb.sw_set),
    .sw_clr(wstb.sw_clr),
    .src   (src_lvl),
    .sw_q  (sw_q),
    .raw   (raw)
  );

  dintc_out_gen #(.N(N)) u_out (
    .clk  (clk),
    .rst_n(rst_n),
    .raw  (raw),
    .ien  (irq_en),
    .fen  (fiq_en),
    .irq_q(irq_out),
    .fiq_q(fiq_out)
  );

  always_comb begin
    unique case (rsel)
      RS_RAW:     rd_mux = raw;
      RS_IMASKED: rd_mux = raw & irq_en;
      RS_FMASKED: rd_mux = raw & fiq_en;
      RS_IEN:     rd_mux = irq_en;
      RS_FEN:     rd_mux = fiq_en;
      RS_SWBIT:   rd_mux = {{(N-1){1'b0}}, raw[0]};
      default:    rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) begin
        rsp_rdata <= rd_mux;
      end
    end
  end

endmodule

// File: rtl/dual_intc_chk.sv
module dual_intc_chk #(
  parameter int unsigned N  = 32,
  parameter int unsigned AW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [N-1:0]  req_wdata,
  input logic          rsp_valid,
  input logic          irq_out,
  input logic          fiq_out,
  input logic [N-1:0]  raw,
  input logic [N-1:0]  irq_en,
  input logic [N-1:0]  fiq_en,
  input logic          sw_q
);
  logic armed;
  logic [AW-3:0] idx;
  logic wr;

  assign idx = req_addr[AW-1:2];
  assign wr  = req_valid && req_write;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) armed <= 1'b0;
    else        armed <= 1'b1;
  end

  p_irq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    irq_out == $past(|(raw & irq_en)));

  p_fiq_follows_r7: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    fiq_out == $past(|(raw & fiq_en)));

  p_rsp_timing_r11: assert property (@(posedge clk) disable iff (!rst_n || !armed)
    rsp_valid == $past(req_valid && !req_write));

  p_ien_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 2) |=> (irq_en == ($past(irq_en) | $past(req_wdata))));

  p_ien_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 3) |=> (irq_en == ($past(irq_en) & ~$past(req_wdata))));

  p_fen_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 10) |=> (fiq_en == ($past(fiq_en) | $past(req_wdata))));

  p_fen_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 11) |=> (fiq_en == ($past(fiq_en) & ~$past(req_wdata))));

  p_sw_set_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 4 && req_wdata[0]) |=> sw_q);

  p_sw_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && idx == 5 && req_wdata[0]) |=> !sw_q);

  p_status_wr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && (idx == 0 || idx == 1 || idx == 8 || idx == 9))
      |=> ($stable(irq_en) && $stable(fiq_en) && $stable(sw_q)));

endmodule

bind dual_intc dual_intc_chk #(.N(N), .AW(AW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_write(req_write),
  .req_addr (req_addr),
  .req_wdata(req_wdata),
  .rsp_valid(rsp_valid),
  .irq_out  (irq_out),
  .fiq_out  (fiq_out),
  .raw      (raw),
  .irq_en   (irq_en),
  .fiq_en   (fiq_en),
  .sw_q     (sw_q)
);

// File: tb/dual_intc_bench.sv
`timescale 1ns/1ps
module dual_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] src_lvl = '0;
  logic        req_valid = 1'b0;
  logic        req_write = 1'b0;
  logic [7:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid;
  logic [31:0] rsp_rdata;
  logic        irq_out;
  logic        fiq_out;

  int n_checks = 0;
  int n_errors = 0;

  always #2 clk = ~clk;

  dual_intc u_dual_intc (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .req_valid(req_valid), .req_write(req_write), .req_addr(req_addr),
    .req_wdata(req_wdata), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .irq_out(irq_out), .fiq_out(fiq_out)
  );

  typedef struct packed {
    logic [1:0]  op;    // 1 = write, 2 = read
    logic [5:0]  idx;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [31:0] exp;
    logic        irq;
    logic        fiq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 35;
  localparam vec_t VECS [NV] = '{
    '{2'd1, 6'd2,  32'h0000_00F0, 32'h0,          32'h0,          1'b0, 1'b0, 8'd3},  // R3
    '{2'd2, 6'd0,  32'h0,         32'h10,         32'h10,         1'b1, 1'b0, 8'd5},  // R5
    '{2'd2, 6'd1,  32'h0,         32'h10,         32'h10,         1'b1, 1'b0, 8'd2},  // R2
    '{2'd1, 6'd10, 32'h0000_0110, 32'h10,         32'h0,          1'b1, 1'b1, 8'd4},  // R4
    '{2'd2, 6'd8,  32'h0,         32'h100,        32'h100,        1'b0, 1'b1, 8'd5},  // R5
    '{2'd1, 6'd3,  32'hFFFF_FFFF, 32'h100,        32'h0,          1'b0, 1'b1, 8'd3},  // R3
    '{2'd2, 6'd2,  32'h0,         32'h100,        32'h0,          1'b0, 1'b1, 8'd3},  // R3
    '{2'd1, 6'd11, 32'h0000_0100, 32'h0,          32'h0,          1'b0, 1'b0, 8'd4},  // R4
    '{2'd2, 6'd10, 32'h0,         32'h0,          32'h10,         1'b0, 1'b0, 8'd4},  // R4
    '{2'd1, 6'd4,  32'hFFFF_FFFE, 32'h0,          32'h0,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd1,  32'h0,         32'h0,          32'h0,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd1, 6'd4,  32'h1,         32'h0,          32'h0,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd4,  32'h0,         32'h0,          32'h1,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd1,  32'h0,         32'h0,          32'h1,          1'b0, 1'b0, 8'd2},  // R2
    '{2'd1, 6'd2,  32'h1,         32'h0,          32'h0,          1'b1, 1'b0, 8'd7},  // R7
    '{2'd2, 6'd0,  32'h0,         32'h0,          32'h1,          1'b1, 1'b0, 8'd5},  // R5
    '{2'd1, 6'd0,  32'hFFFF_FFFF, 32'h0,          32'h0,          1'b1, 1'b0, 8'd9},  // R9
    '{2'd1, 6'd1,  32'hFFFF_FFFF, 32'h0,          32'h0,          1'b1, 1'b0, 8'd9},  // R9
    '{2'd1, 6'd8,  32'hFFFF_FFFF, 32'h0,          32'h0,          1'b1, 1'b0, 8'd9},  // R9
    '{2'd1, 6'd9,  32'hFFFF_FFFF, 32'h0,          32'h0,          1'b1, 1'b0, 8'd9},  // R9
    '{2'd2, 6'd2,  32'h0,         32'h0,          32'h1,          1'b1, 1'b0, 8'd9},  // R9
    '{2'd2, 6'd10, 32'h0,         32'h0,          32'h10,         1'b1, 1'b0, 8'd9},  // R9
    '{2'd2, 6'd3,  32'h0,         32'h0,          32'h0,          1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 6'd5,  32'h0,         32'h0,          32'h0,          1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 6'd11, 32'h0,         32'h0,          32'h0,          1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 6'd6,  32'h0,         32'h0,          32'h0,          1'b1, 1'b0, 8'd8},  // R8
    '{2'd2, 6'd15, 32'h0,         32'h0,          32'h0,          1'b1, 1'b0, 8'd8},  // R8
    '{2'd1, 6'd5,  32'hFFFF_FFFE, 32'h0,          32'h0,          1'b1, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd4,  32'h0,         32'h0,          32'h1,          1'b1, 1'b0, 8'd6},  // R6
    '{2'd1, 6'd5,  32'h1,         32'h0,          32'h0,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd4,  32'h0,         32'h0,          32'h0,          1'b0, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd1,  32'h0,         32'h1,          32'h1,          1'b1, 1'b0, 8'd2},  // R2
    '{2'd2, 6'd4,  32'h0,         32'h1,          32'h1,          1'b1, 1'b0, 8'd6},  // R6
    '{2'd2, 6'd1,  32'h0,         32'h8000_0001,  32'h8000_0001,  1'b1, 1'b0, 8'd2},  // R2
    '{2'd1, 6'd11, 32'hFFFF_FFFF, 32'h10,         32'h0,          1'b0, 1'b0, 8'd4}   // R4
  };

  task automatic chk(input int req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_op(input logic wr, input logic [7:0] addr, input logic [31:0] wd,
                        output logic [31:0] rd, output logic rv);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    rd = rsp_rdata; rv = rsp_valid;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_errors++;
    n_checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic        rv;

    // R10 reset state
    repeat (3) @(negedge clk);
    chk(10, "irq_out in reset", {31'b0, irq_out}, 32'h0);
    chk(10, "fiq_out in reset", {31'b0, fiq_out}, 32'h0);
    chk(10, "rsp_valid in reset", {31'b0, rsp_valid}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    bus_op(1'b0, 8'd2 << 2, 32'h0, rd, rv);
    chk(10, "IRQ mask after reset", rd, 32'h0);
    chk(11, "rsp_valid on read", {31'b0, rv}, 32'h1);
    bus_op(1'b0, 8'd10 << 2, 32'h0, rd, rv);
    chk(10, "FIQ mask after reset", rd, 32'h0);
    bus_op(1'b0, 8'd4 << 2, 32'h0, rd, rv);
    chk(10, "software bit after reset", rd, 32'h0);

    // vector walk
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      src_lvl = VECS[i].src;
      bus_op(VECS[i].op == 2'd1, {VECS[i].idx, 2'b00}, VECS[i].wdata, rd, rv);
      if (VECS[i].op == 2'd2) begin
        chk(int'(VECS[i].req), $sformatf("vec %0d read idx %0d", i, VECS[i].idx), rd, VECS[i].exp);
      end else begin
        chk(11, $sformatf("vec %0d no response to write", i), {31'b0, rv}, 32'h0);
      end
      @(negedge clk);
      chk(7, $sformatf("vec %0d irq_out", i), {31'b0, irq_out}, {31'b0, VECS[i].irq});
      chk(7, $sformatf("vec %0d fiq_out", i), {31'b0, fiq_out}, {31'b0, VECS[i].fiq});
    end

    // R1: low address bits ignored; IRQ mask is 0x1 here
    bus_op(1'b0, 8'h0B, 32'h0, rd, rv);
    chk(1, "addr 0x0B decodes index 2", rd, 32'h1);
    bus_op(1'b1, 8'h0A, 32'h0000_0004, rd, rv);   // index 2 set, bits 1:0 = 2'b10
    bus_op(1'b0, 8'h09, 32'h0, rd, rv);
    chk(1, "write via addr 0x0A", rd, 32'h5);

    // R7: output changes one cycle after source
    @(negedge clk);
    src_lvl = 32'h4;
    @(negedge clk);
    chk(7, "irq one cycle after source", {31'b0, irq_out}, 32'h1);
    src_lvl = 32'h0;
    @(negedge clk);
    chk(7, "irq drops with source", {31'b0, irq_out}, 32'h0);

    // R10: reset in the middle of operation
    bus_op(1'b1, 8'd10 << 2, 32'hFFFF_FFFF, rd, rv);
    bus_op(1'b1, 8'd4 << 2, 32'h1, rd, rv);
    src_lvl = 32'hFFFF_FFFF;
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(10, "fiq_out low in reset", {31'b0, fiq_out}, 32'h0);
    rst_n = 1'b1;
    src_lvl = 32'h0;
    bus_op(1'b0, 8'd10 << 2, 32'h0, rd, rv);
    chk(10, "FIQ mask cleared by reset", rd, 32'h0);
    bus_op(1'b0, 8'd2 << 2, 32'h0, rd, rv);
    chk(10, "IRQ mask cleared by reset", rd, 32'h0);
    bus_op(1'b0, 8'd1 << 2, 32'h0, rd, rv);
    chk(10, "software latch cleared by reset", rd, 32'h0);

    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end
endmodule